// File: doc/BRIEF.md
# DMA channel control register block

This block holds the software-visible registers of one DMA channel that sits next to a storage bus controller. It has four 32-bit word registers on a simple synchronous host bus. Word 0 is control and status, word 1 holds the transfer address, and words 2 and 3 are spare storage. Values written to the control word are rewritten before they are stored. A reset bit sends a one-cycle reset pulse to the attached controller. Bit 6 is cleared when written alone, an all-zero write is turned into a set bit 6, and a fixed version code always fills the top nibble.

The attached controller reports interrupts through a pending bit in the control word. A post pulse sets the bit, and an acknowledge pulse clears it when the controller's own interrupt register is read. The channel interrupt output is the registered AND of the pending bit and an enable bit. Writing the address word marks the channel as loaded. The memory transfer itself and any address translation are handled elsewhere.

Top module: `dma_chan_regs`

## Requirements
- R1: The word is selected by `addr[3:2]` (0 control, 1 address, 2 and 3 spare). `addr[1:0]` has no effect. `rdata` combinationally shows the stored value of the selected word.
- R2: After reset, control reads 0xA0000000, the other three words read 0, and `irq` and `ctl_reset` are low.
- R3: A control write with bit 7 set drives `ctl_reset` high for exactly the next cycle. The value is stored without the bit 6 or zero rewriting, so bit 7 stays set.
- R4: A control write with bit 7 clear and bit 6 set stores the value with bit 6 cleared.
- R5: A control write of exactly 0 stores 0x40 in the low 28 bits, so control reads 0xA0000040.
- R6: Every stored control value has bits [27:0] from the (rewritten) write data and bits [31:28] forced to 0xA. The top nibble reads 0xA at all times.
- R7: A write to word 1 stores the data there and sets bit 26 (loaded) of the control word. The other control bits are unchanged.
- R8: Control bit 0 is interrupt-pending. A pulse on `irq_post` sets it and a pulse on `irq_ack` clears it. Both are applied after a same-cycle host write, and post wins over ack.
- R9: `irq` is a register that equals, one cycle later, control bit 0 AND control bit 4 (interrupt enable). A control write that clears bit 4 therefore drops `irq` one cycle after the write has been stored.
- R10: Words 2 and 3 store and return any 32-bit value unchanged, with no effect on the control word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Byte address; bits [3:2] select the word |
| wr_en | input | 1 | Write strobe for the selected word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the selected word |
| irq_post | input | 1 | Controller posts an interrupt |
| irq_ack | input | 1 | Controller interrupt register was read |
| ctl_reset | output | 1 | One-cycle reset pulse to the controller |
| irq | output | 1 | Channel interrupt output |

## Verification
The bench uses the default parameters: 32-bit words and a version nibble of 0xA. With these values the expected control words can be written as constants, such as 0xA0000040 for the zero write and 0xA4000000 after loading. A behavioural model of all four words runs alongside the design and is compared on every clock. That comparison catches same-cycle collisions of a host write with post or acknowledge, which the directed phases would not otherwise reach. The directed phases cover the bit 7, bit 6 and zero-write cases separately, because each one takes its own branch of the rewriting logic.

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int DW = 32,
  parameter logic [3:0] VERSION = 4'hA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          irq_post,
  input  logic          irq_ack,
  output logic          ctl_reset,
  output logic          irq
);
  localparam logic [DW-1:0] VER_WORD = {VERSION, {(DW-4){1'b0}}};
  localparam logic [DW-1:0] LOW_MASK = {4'h0, {(DW-4){1'b1}}};
  localparam int B_PEND = 0;
  localparam int B_EN   = 4;
  localparam int B_ZERO = 6;
  localparam int B_RST  = 7;
  localparam int B_LOAD = 26;

  logic [DW-1:0] ctrl_q, addr_q, spare2_q, spare3_q;
  logic [DW-1:0] ctrl_wr, ctrl_nxt;
  logic [1:0]    sel;

  assign sel = addr[3:2];

  always_comb begin
    ctrl_wr = wdata;
    if (!wdata[B_RST]) begin
      if (wdata[B_ZERO]) ctrl_wr[B_ZERO] = 1'b0;
      else if (wdata == '0) ctrl_wr[B_ZERO] = 1'b1;
    end
    ctrl_wr = (ctrl_wr & LOW_MASK) | VER_WORD;
  end

  always_comb begin
    ctrl_nxt = ctrl_q;
    if (wr_en && sel == 2'd0) ctrl_nxt = ctrl_wr;
    if (wr_en && sel == 2'd1) ctrl_nxt[B_LOAD] = 1'b1;
    if (irq_ack)  ctrl_nxt[B_PEND] = 1'b0;
    if (irq_post) ctrl_nxt[B_PEND] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= VER_WORD;
      addr_q    <= '0;
      spare2_q  <= '0;
      spare3_q  <= '0;
      ctl_reset <= 1'b0;
      irq       <= 1'b0;
    end else begin
      ctrl_q    <= ctrl_nxt;
      if (wr_en && sel == 2'd1) addr_q   <= wdata;
      if (wr_en && sel == 2'd2) spare2_q <= wdata;
      if (wr_en && sel == 2'd3) spare3_q <= wdata;
      ctl_reset <= wr_en && sel == 2'd0 && wdata[B_RST];
      irq       <= ctrl_q[B_PEND] & ctrl_q[B_EN];
    end
  end

  always_comb begin
    case (sel)
      2'd0:    rdata = ctrl_q;
      2'd1:    rdata = addr_q;
      2'd2:    rdata = spare2_q;
      default: rdata = spare3_q;
    endcase
  end

  p_version_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[DW-1:DW-4] == VERSION);
  p_reset_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == 2'd0 && wdata[B_RST]) |=> ctl_reset);
  p_reset_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sel == 2'd0 && wdata[B_RST]) |=> !ctl_reset);
  p_loaded_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == 2'd1) |=> ctrl_q[B_LOAD]);
  p_post_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_post |=> ctrl_q[B_PEND]);
  p_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !irq_post && !(wr_en && sel == 2'd0)) |=> !ctrl_q[B_PEND]);
  p_irq_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[B_EN] |=> !irq);
  p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == 2'd0 && wdata == '0 && !irq_post) |=> ctrl_q == (VER_WORD | (1 << B_ZERO)));
endmodule

// File: tb/dma_chan_regs_tb.sv
module dma_chan_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_post = 1'b0;
  logic        irq_ack = 1'b0;
  logic        ctl_reset;
  logic        irq;

  int checks = 0;
  int fails = 0;
  string tag = "R2";
  bit done = 1'b0;

  logic [31:0] m_word [4];
  logic        m_irq, m_rst;

  always #5 clk = ~clk;

  dma_chan_regs u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .irq_post(irq_post), .irq_ack(irq_ack),
    .ctl_reset(ctl_reset), .irq(irq)
  );

  always @(posedge clk) begin
    logic [31:0] v;
    logic        ni, nr;
    if (!rst_n) begin
      m_word[0] = 32'hA000_0000;
      m_word[1] = 0; m_word[2] = 0; m_word[3] = 0;
      m_irq = 0; m_rst = 0;
    end else begin
      ni = m_word[0][0] & m_word[0][4];
      nr = 0;
      if (wr_en) begin
        case (addr[3:2])
          2'd0: begin
            v = wdata;
            if (v[7]) nr = 1;
            else if (v[6]) v[6] = 0;
            else if (v == 0) v = 32'h40;
            m_word[0] = (v & 32'h0FFF_FFFF) | 32'hA000_0000;
          end
          2'd1: begin m_word[1] = wdata; m_word[0][26] = 1; end
          2'd2: m_word[2] = wdata;
          default: m_word[3] = wdata;
        endcase
      end
      if (irq_ack) m_word[0][0] = 0;
      if (irq_post) m_word[0][0] = 1;
      m_irq = ni; m_rst = nr;
    end
    #2;
    checks++;
    if (rdata !== m_word[addr[3:2]] || irq !== m_irq || ctl_reset !== m_rst) begin
      fails++;
      $display("FAIL %s: rdata=%h irq=%b rst=%b expected rdata=%h irq=%b rst=%b",
               tag, rdata, irq, ctl_reset, m_word[addr[3:2]], m_irq, m_rst);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string t);
    @(negedge clk); addr = a; #1;
    checks++;
    if (rdata !== exp) begin
      fails++;
      $display("FAIL %s: rdata=%h expected %h", t, rdata, exp);
    end
  endtask

  task automatic pulse(input bit p, input bit k);
    @(negedge clk); irq_post = p; irq_ack = k;
    @(negedge clk); irq_post = 0; irq_ack = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R2";
    rd_chk(4'h0, 32'hA000_0000, "R2 ctrl reset");
    rd_chk(4'h4, 32'h0, "R2 addr reset");
    rd_chk(4'hC, 32'h0, "R2 spare reset");

    tag = "R5"; wr(4'h0, 32'h0);
    rd_chk(4'h0, 32'hA000_0040, "R5 zero write");
    tag = "R4"; wr(4'h0, 32'h0000_0050);
    rd_chk(4'h0, 32'hA000_0010, "R4 bit6 cleared");
    tag = "R6"; wr(4'h0, 32'h5123_4501);
    rd_chk(4'h0, 32'hA123_4501, "R6 version forced");
    tag = "R3"; wr(4'h0, 32'h0000_00C0);
    rd_chk(4'h0, 32'hA000_00C0, "R3 reset write kept");
    tag = "R7"; wr(4'h0, 32'h0000_0001); wr(4'h4, 32'hDEAD_BEEF);
    rd_chk(4'h5, 32'hDEAD_BEEF, "R7 address stored (R1 low bits)");
    rd_chk(4'h2, 32'hA400_0001, "R7 loaded flag (R1 low bits)");
    tag = "R10"; wr(4'h8, 32'h1234_5678); wr(4'hF, 32'h8765_4321);
    rd_chk(4'hA, 32'h1234_5678, "R10 spare2");
    rd_chk(4'hC, 32'h8765_4321, "R10 spare3");
    rd_chk(4'h0, 32'hA400_0001, "R10 ctrl untouched");

    tag = "R8"; wr(4'h0, 32'h0000_0010);
    pulse(1, 0); rd_chk(4'h0, 32'hA000_0011, "R8 post sets");
    tag = "R9"; repeat (2) @(negedge clk);
    checks++; if (irq !== 1) begin fails++; $display("FAIL R9: irq=%b expected 1", irq); end
    wr(4'h0, 32'h0000_0001); @(negedge clk);
    checks++; if (irq !== 0) begin fails++; $display("FAIL R9: irq=%b expected 0", irq); end
    tag = "R8"; pulse(0, 1); rd_chk(4'h0, 32'hA000_0000, "R8 ack clears");
    pulse(1, 1); rd_chk(4'h0, 32'hA000_0001, "R8 post beats ack");

    tag = "R1 random";
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      addr = 4'($urandom);
      wr_en = ($urandom % 3) == 0;
      case ($urandom % 4)
        0: wdata = 0;
        1: wdata = 32'h40 | ($urandom & 32'h90);
        default: wdata = $urandom;
      endcase
      irq_post = ($urandom % 5) == 0;
      irq_ack = ($urandom % 5) == 0;
    end
    @(negedge clk); wr_en = 0; irq_post = 0; irq_ack = 0;
    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run hung, expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule